// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Selective Invalidation

This block is a small fully associative cache of page translations. Each entry holds a linear page number, the physical frame it maps to, a global flag and a 16-bit context identifier naming the address space that owns it. A lookup presents a page number under the current identifier. It returns a hit, together with the frame and the global flag, only when an entry matches both the identifier and the page number. Identifier zero belongs to the host, so guests are given non-zero identifiers.

The fill port installs translations produced by an external page walker. A fill whose identifier and page already sit in the cache rewrites that entry in place. Otherwise it takes a free slot or, when the cache is full, a round-robin victim.

A separate command port removes entries. It takes an extent code, an identifier and a 64-bit linear address, and can drop one page, one whole context, one context except its global pages, or everything. With tagging enabled, moving between contexts keeps the contents intact. With tagging disabled, all traffic runs under the host identifier and any change of the current context empties the cache.

Top module: `ctxtlb`

## Requirements
- R1: With `lk_valid` high, `lk_hit` is high in the same cycle only if a valid entry carries both the effective identifier and `lk_vpn`; on a hit, `lk_pfn` and `lk_global` give that entry's frame and global flag.
- R2: The effective identifier is `cur_ctx` when `tag_en` is 1 and 0x0000 (host) when `tag_en` is 0. It is used for both lookups and fills. An entry filled under identifier 5 misses for a lookup under identifier 0 or 6.
- R3: With `tag_en` high, a change of `cur_ctx` removes no entry.
- R4: With `tag_en` low, a change of `cur_ctx` from its value at the previous clock edge invalidates every entry at that edge.
- R5: Extent code 0 (address) removes the entry whose identifier equals `inv_ctx` and whose page equals `inv_addr[63:12]`. No other entry is touched.
- R6: Extent code 1 (context) removes every entry whose identifier equals `inv_ctx`.
- R7: Extent code 2 (context, keep globals) removes every non-global entry whose identifier equals `inv_ctx` and keeps that identifier's global entries.
- R8: Extent code 3 (all contexts) removes every entry.
- R9: Extent codes 4 to 7 are rejected. `inv_err` is high for exactly the cycle after the command, and the contents are left unchanged.
- R10: Every command takes effect at the next clock edge. A fill issued in the same cycle as a command is discarded.
- R11: A fill whose effective identifier and page match a valid entry overwrites that entry in place, so at most one entry ever hits.
- R12: A fill that does not match an entry goes to the lowest-indexed free entry. When no entry is free, it goes to the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one after each such eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all entries |
| tag_en | input | 1 | Context tagging enable |
| cur_ctx | input | 16 | Current context identifier |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 52 | Lookup linear page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 28 | Physical frame on hit |
| lk_global | output | 1 | Global flag of the hit entry |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 52 | Fill linear page number |
| fl_pfn | input | 28 | Fill physical frame |
| fl_global | input | 1 | Fill global flag |
| inv_valid | input | 1 | Invalidation command strobe |
| inv_kind | input | 3 | Extent code (0 address, 1 context, 2 context keep globals, 3 all) |
| inv_ctx | input | 16 | Identifier operand |
| inv_addr | input | 64 | Linear address operand |
| inv_err | output | 1 | Undefined extent rejected (one cycle) |

## Verification
The bench aims at entries that share a page number across identifiers. A design that compared only the page, or only the identifier, would return the wrong frame, or hit under the host identifier. The keep-globals extent is run against a context holding one global and one non-global page, and an undefined code is sent against a loaded cache. A design that ignored the global flag, or treated unknown codes as a flush, would lose the wrong entries. The bench also fills the cache past capacity, rewrites an existing page, collides a fill with a command, and switches contexts with tagging off and on, which exposes a wrong victim, a duplicated entry, a fill that beats its command, and a missing or spurious flush.

// File: rtl/ctxtlb_pkg.sv
package ctxtlb_pkg;
    localparam int unsigned CTX_W      = 16;
    localparam int unsigned ADDR_W     = 64;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned VPN_W      = ADDR_W - PAGE_SHIFT;
    localparam int unsigned PFN_W      = 28;
    localparam int unsigned KIND_W     = 3;

    localparam logic [CTX_W-1:0] HOST_CTX = '0;

    typedef enum logic [KIND_W-1:0] {
        INV_PAGE      = 3'd0,
        INV_SPACE     = 3'd1,
        INV_SPACE_KG  = 3'd2,
        INV_EVERY     = 3'd3
    } inv_kind_e;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;

    function automatic logic kind_known(input logic [KIND_W-1:0] k);
        return k <= KIND_W'(INV_EVERY);
    endfunction

    function automatic logic [VPN_W-1:0] addr_to_vpn(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:PAGE_SHIFT];
    endfunction
endpackage

// File: rtl/ctxtlb_match.sv
module ctxtlb_match
    import ctxtlb_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  tlb_entry_t [N-1:0] ents,
    input  logic [CTX_W-1:0]   ctx,
    input  logic [VPN_W-1:0]   vpn,
    output logic [N-1:0]       hit_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = ents[i].valid && (ents[i].ctx == ctx) && (ents[i].vpn == vpn);
    end
endmodule

// File: rtl/ctxtlb_inval.sv
module ctxtlb_inval
    import ctxtlb_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  tlb_entry_t [N-1:0] ents,
    input  logic               cmd_valid,
    input  logic [KIND_W-1:0]  cmd_kind,
    input  logic [CTX_W-1:0]   cmd_ctx,
    input  logic [ADDR_W-1:0]  cmd_addr,
    output logic [N-1:0]       kill_vec,
    output logic               cmd_bad
);
    logic [VPN_W-1:0] cmd_vpn;
    assign cmd_vpn = addr_to_vpn(cmd_addr);
    assign cmd_bad = cmd_valid && !kind_known(cmd_kind);

    for (genvar i = 0; i < N; i++) begin : g_kill
        logic same_ctx;
        assign same_ctx = ents[i].ctx == cmd_ctx;
        always_comb begin
            kill_vec[i] = 1'b0;
            if (cmd_valid && ents[i].valid) begin
                case (cmd_kind)
                    INV_PAGE:     kill_vec[i] = same_ctx && (ents[i].vpn == cmd_vpn);
                    INV_SPACE:    kill_vec[i] = same_ctx;
                    INV_SPACE_KG: kill_vec[i] = same_ctx && !ents[i].glob;
                    INV_EVERY:    kill_vec[i] = 1'b1;
                    default:      kill_vec[i] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctxtlb_repl.sv
module ctxtlb_repl #(
    parameter int unsigned N = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_vec,
    input  logic             alloc,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim = any_free ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc && !any_free) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    assert_victim_range_R12: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (32'(victim) < N));
    assert_free_first_R12: assert property (@(posedge clk) disable iff (rst)
        (alloc && !(&valid_vec)) |-> !valid_vec[victim]);
endmodule

// File: rtl/ctxtlb.sv
module ctxtlb
    import ctxtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tag_en,
    input  logic [CTX_W-1:0]  cur_ctx,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_global,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic              fl_global,
    input  logic              inv_valid,
    input  logic [KIND_W-1:0] inv_kind,
    input  logic [CTX_W-1:0]  inv_ctx,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_err
);
    tlb_entry_t [ENTRIES-1:0] ent_q;
    logic [ENTRIES-1:0]       valid_vec;
    logic [CTX_W-1:0]         eff_ctx;
    logic [CTX_W-1:0]         ctx_q;
    logic                     sw_flush;
    logic [ENTRIES-1:0]       lk_vec, fl_vec, kill_vec;
    logic                     cmd_bad;
    logic                     fill_ok, fill_hit, alloc;
    logic [IDX_W-1:0]         fill_idx, match_idx, victim;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
        assign valid_vec[i] = ent_q[i].valid;
    end

    assign eff_ctx  = tag_en ? cur_ctx : HOST_CTX;
    assign sw_flush = !tag_en && (cur_ctx != ctx_q);

    ctxtlb_match #(.N(ENTRIES)) u_lk_match (
        .ents(ent_q), .ctx(eff_ctx), .vpn(lk_vpn), .hit_vec(lk_vec)
    );

    ctxtlb_match #(.N(ENTRIES)) u_fl_match (
        .ents(ent_q), .ctx(eff_ctx), .vpn(fl_vpn), .hit_vec(fl_vec)
    );

    ctxtlb_inval #(.N(ENTRIES)) u_inval (
        .ents(ent_q), .cmd_valid(inv_valid), .cmd_kind(inv_kind),
        .cmd_ctx(inv_ctx), .cmd_addr(inv_addr),
        .kill_vec(kill_vec), .cmd_bad(cmd_bad)
    );

    assign fill_ok  = fl_valid && !inv_valid && !sw_flush;
    assign fill_hit = |fl_vec;
    assign alloc    = fill_ok && !fill_hit;

    ctxtlb_repl #(.N(ENTRIES)) u_repl (
        .clk(clk), .rst(rst), .valid_vec(valid_vec), .alloc(alloc), .victim(victim)
    );

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fl_vec[i]) match_idx = IDX_W'(i);
        end
    end
    assign fill_idx = fill_hit ? match_idx : victim;

    always_comb begin
        lk_hit    = 1'b0;
        lk_pfn    = '0;
        lk_global = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_valid && lk_vec[i]) begin
                lk_hit    = 1'b1;
                lk_pfn    = lk_pfn | ent_q[i].pfn;
                lk_global = lk_global | ent_q[i].glob;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q   <= HOST_CTX;
            inv_err <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            ctx_q   <= cur_ctx;
            inv_err <= cmd_bad;
            for (int i = 0; i < ENTRIES; i++) begin
                if (sw_flush || kill_vec[i]) begin
                    ent_q[i].valid <= 1'b0;
                end else if (fill_ok && (fill_idx == IDX_W'(i))) begin
                    ent_q[i].valid <= 1'b1;
                    ent_q[i].glob  <= fl_global;
                    ent_q[i].ctx   <= eff_ctx;
                    ent_q[i].vpn   <= fl_vpn;
                    ent_q[i].pfn   <= fl_pfn;
                end
            end
        end
    end

    assert_single_hit_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec));
    assert_no_implicit_flush_R3: assert property (@(posedge clk) disable iff (rst)
        (tag_en && !inv_valid) |=> ((valid_vec & $past(valid_vec)) == $past(valid_vec)));
    assert_all_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_kind == KIND_W'(INV_EVERY)) |=> (valid_vec == '0));
    assert_bad_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !kind_known(inv_kind) && !sw_flush) |=> (valid_vec == $past(valid_vec)));
    assert_err_source_R9: assert property (@(posedge clk) disable iff (rst)
        inv_err |-> ($past(inv_valid) && $past(inv_kind) > 3'd3));
    assert_cmd_beats_fill_R10: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && fl_valid) |=> ((valid_vec & ~$past(valid_vec)) == '0));
    assert_flush_on_switch_R4: assert property (@(posedge clk) disable iff (rst)
        (!tag_en && cur_ctx != ctx_q) |=> (valid_vec == '0));
endmodule

// File: tb/ctxtlb_tb.sv
module ctxtlb_tb;
    import ctxtlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 52;
    localparam int NSTEP = 10;
    // {is_lookup, ctx[15:0], vpn[15:0], pfn[15:0], glob, exp_hit, exp_glob}
    localparam logic [TW-1:0] TBL [NSTEP] = '{
        {1'b0, 16'h0005, 16'h0010, 16'h0100, 1'b0, 1'b0, 1'b0},
        {1'b0, 16'h0005, 16'h0011, 16'h0101, 1'b1, 1'b0, 1'b0},
        {1'b0, 16'h0007, 16'h0010, 16'h0200, 1'b0, 1'b0, 1'b0},
        {1'b1, 16'h0005, 16'h0010, 16'h0100, 1'b0, 1'b1, 1'b0},
        {1'b1, 16'h0007, 16'h0010, 16'h0200, 1'b0, 1'b1, 1'b0},
        {1'b1, 16'h0006, 16'h0010, 16'h0000, 1'b0, 1'b0, 1'b0},
        {1'b1, 16'h0005, 16'h0011, 16'h0101, 1'b0, 1'b1, 1'b1},
        {1'b1, 16'h0000, 16'h0010, 16'h0000, 1'b0, 1'b0, 1'b0},
        {1'b1, 16'h0007, 16'h0011, 16'h0000, 1'b0, 1'b0, 1'b0},
        {1'b1, 16'h0007, 16'h0010, 16'h0200, 1'b0, 1'b1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              tag_en;
    logic [CTX_W-1:0]  cur_ctx;
    logic              lk_valid;
    logic [VPN_W-1:0]  lk_vpn;
    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic              lk_global;
    logic              fl_valid;
    logic [VPN_W-1:0]  fl_vpn;
    logic [PFN_W-1:0]  fl_pfn;
    logic              fl_global;
    logic              inv_valid;
    logic [KIND_W-1:0] inv_kind;
    logic [CTX_W-1:0]  inv_ctx;
    logic [ADDR_W-1:0] inv_addr;
    logic              inv_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctxtlb u_dut (
        .clk(clk), .rst(rst), .tag_en(tag_en), .cur_ctx(cur_ctx),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .lk_global(lk_global), .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
        .fl_global(fl_global), .inv_valid(inv_valid), .inv_kind(inv_kind),
        .inv_ctx(inv_ctx), .inv_addr(inv_addr), .inv_err(inv_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [15:0] ctx, input logic [15:0] vpn,
                        input logic [15:0] pfn, input logic g);
        @(negedge clk);
        cur_ctx   = ctx;
        fl_valid  = 1'b1;
        fl_vpn    = VPN_W'(vpn);
        fl_pfn    = PFN_W'(pfn);
        fl_global = g;
        @(negedge clk);
        fl_valid  = 1'b0;
    endtask

    task automatic look(input string req, input logic [15:0] ctx, input logic [15:0] vpn,
                        input logic exp_hit, input logic [15:0] exp_pfn, input logic exp_g);
        @(negedge clk);
        cur_ctx  = ctx;
        lk_valid = 1'b1;
        lk_vpn   = VPN_W'(vpn);
        #1;
        check(req, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) begin
            check(req, 64'(lk_pfn), 64'(exp_pfn));
            check(req, 64'(lk_global), 64'(exp_g));
        end
        lk_valid = 1'b0;
    endtask

    task automatic inval(input logic [2:0] kind, input logic [15:0] ctx,
                         input logic [15:0] vpn, input logic exp_err, input string req);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_kind  = kind;
        inv_ctx   = ctx;
        inv_addr  = {36'h0, vpn, 12'hABC};
        @(negedge clk);
        inv_valid = 1'b0;
        check(req, 64'(inv_err), 64'(exp_err));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; tag_en = 1'b1; cur_ctx = '0; lk_valid = 1'b0; lk_vpn = '0;
        fl_valid = 1'b0; fl_vpn = '0; fl_pfn = '0; fl_global = 1'b0;
        inv_valid = 1'b0; inv_kind = '0; inv_ctx = '0; inv_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        look("R1 reset miss", 16'h0, 16'h0, 1'b0, 16'h0, 1'b0);
        check("R9 reset err low", 64'(inv_err), 64'd0);

        // vector table: R1/R2/R3 (ctx 0 and 6 miss; switching contexts keeps ctx 7)
        for (int i = 0; i < NSTEP; i++) begin
            if (TBL[i][51]) look("R1 R2 R3 table", TBL[i][50:35], TBL[i][34:19],
                                 TBL[i][1], TBL[i][18:3], TBL[i][0]);
            else fill(TBL[i][50:35], TBL[i][34:19], TBL[i][18:3], TBL[i][2]);
        end

        // R11: overwrite in place
        fill(16'h5, 16'h10, 16'h155, 1'b0);
        look("R11 overwrite", 16'h5, 16'h10, 1'b1, 16'h155, 1'b0);

        // R5: address extent
        inval(3'd0, 16'h5, 16'h11, 1'b0, "R5 err");
        look("R5 removed", 16'h5, 16'h11, 1'b0, 16'h0, 1'b0);
        look("R5 neighbour kept", 16'h5, 16'h10, 1'b1, 16'h155, 1'b0);
        look("R5 other ctx kept", 16'h7, 16'h10, 1'b1, 16'h200, 1'b0);

        // R7: keep globals
        fill(16'h5, 16'h20, 16'h300, 1'b1);
        fill(16'h5, 16'h21, 16'h301, 1'b0);
        inval(3'd2, 16'h5, 16'h0, 1'b0, "R7 err");
        look("R7 global kept", 16'h5, 16'h20, 1'b1, 16'h300, 1'b1);
        look("R7 nonglobal gone", 16'h5, 16'h21, 1'b0, 16'h0, 1'b0);
        look("R7 nonglobal gone b", 16'h5, 16'h10, 1'b0, 16'h0, 1'b0);
        look("R7 other ctx kept", 16'h7, 16'h10, 1'b1, 16'h200, 1'b0);

        // R6: context extent
        inval(3'd1, 16'h5, 16'h0, 1'b0, "R6 err");
        look("R6 global gone", 16'h5, 16'h20, 1'b0, 16'h0, 1'b0);
        look("R6 other ctx kept", 16'h7, 16'h10, 1'b1, 16'h200, 1'b0);

        // R9: undefined extent
        inval(3'd5, 16'h7, 16'h10, 1'b1, "R9 err raised");
        check("R9 err one cycle", 64'(inv_err), 64'd1);
        @(negedge clk);
        check("R9 err drops", 64'(inv_err), 64'd0);
        look("R9 contents kept", 16'h7, 16'h10, 1'b1, 16'h200, 1'b0);

        // R10: command beats fill
        @(negedge clk);
        cur_ctx = 16'h9; fl_valid = 1'b1; fl_vpn = VPN_W'(16'h30); fl_pfn = PFN_W'(16'h400);
        fl_global = 1'b0;
        inv_valid = 1'b1; inv_kind = 3'd0; inv_ctx = 16'h1; inv_addr = '0;
        @(negedge clk);
        fl_valid = 1'b0; inv_valid = 1'b0;
        look("R10 fill dropped", 16'h9, 16'h30, 1'b0, 16'h0, 1'b0);

        // R8: all contexts
        inval(3'd3, 16'h0, 16'h0, 1'b0, "R8 err");
        look("R8 all gone", 16'h7, 16'h10, 1'b0, 16'h0, 1'b0);

        // R12: replacement
        for (int v = 0; v < 8; v++) fill(16'h3, 16'(v), 16'(16'h500 + v), 1'b0);
        look("R12 full keeps 0", 16'h3, 16'h0, 1'b1, 16'h500, 1'b0);
        fill(16'h3, 16'h8, 16'h508, 1'b0);
        look("R12 first victim", 16'h3, 16'h0, 1'b0, 16'h0, 1'b0);
        look("R12 new present", 16'h3, 16'h8, 1'b1, 16'h508, 1'b0);
        look("R12 entry1 kept", 16'h3, 16'h1, 1'b1, 16'h501, 1'b0);
        fill(16'h3, 16'h9, 16'h509, 1'b0);
        look("R12 second victim", 16'h3, 16'h1, 1'b0, 16'h0, 1'b0);
        look("R12 entry2 kept", 16'h3, 16'h2, 1'b1, 16'h502, 1'b0);

        // R2/R4: tagging disabled
        @(negedge clk);
        tag_en = 1'b0;
        look("R2 tagged hidden", 16'h3, 16'h2, 1'b0, 16'h0, 1'b0);
        fill(16'h3, 16'h40, 16'h600, 1'b0);
        look("R2 host id hit", 16'h3, 16'h40, 1'b1, 16'h600, 1'b0);
        @(negedge clk);
        cur_ctx = 16'h4;
        @(negedge clk);
        look("R4 flushed host", 16'h4, 16'h40, 1'b0, 16'h0, 1'b0);
        @(negedge clk);
        tag_en = 1'b1;
        look("R4 tagged flushed", 16'h3, 16'h2, 1'b0, 16'h0, 1'b0);

        finish_run();
    end
endmodule